// File: doc/BRIEF.md
# Grouped register peripheral port (pipelined Wishbone slave)

This block is one slave port on a pipelined Wishbone interconnect. It serves a whole group of small register peripherals that share a single interconnect slot. The port does not gather acknowledge or stall from each group member. A parameter fixes the timing class of the group, and that class sets both signals. The return path therefore reduces to one address-indexed selection.

Two classes are offered. In the immediate class, each member is a single 32-bit register that can always be read. Acknowledge follows the strobe in the same cycle, and read data comes straight from the selected register. In the one-cycle class, each member holds several 32-bit registers. Acknowledge is a registered copy of the strobe, and the read word is captured in that same clock edge. The port decodes the word address into one strobe per member. Writes honour the four byte selects. Group slots that are left unpopulated read as zero and ignore writes.

Top module: `wb_reg_group`

## Requirements
- R1: In the immediate class (GRP_CLASS = GRP_IMMEDIATE), o_ack equals i_stb in the same cycle, and o_data shows the addressed register combinationally, with its value before any write in that cycle.
- R2: o_stall and o_err are low in every cycle.
- R3: In the one-cycle class (GRP_CLASS = GRP_ONE_CYCLE), o_ack is high in exactly the cycle after each cycle with i_stb high, and it is low out of reset.
- R4: In the one-cycle class, o_data in the acknowledge cycle holds the addressed register's value as it was in the strobe cycle, before any write in that strobe cycle. o_data is unchanged in cycles that follow no strobe.
- R5: A write (i_stb and i_we high) changes only the byte lanes whose i_sel bit is set: bit 3 enables bits 31:24, bit 2 enables 23:16, bit 1 enables 15:8, and bit 0 enables 7:0. The new value is visible from the next cycle.
- R6: The register index is i_addr[IDX_W-1:0]. Here IDX_W = log2(NUM_MEMBERS) in the immediate class, and log2(NUM_MEMBERS) + log2(REGS_PER_MEMBER) in the one-cycle class. The member number occupies the upper index bits. Higher address bits are ignored, and a write changes only the addressed register.
- R7: Members whose bit in POP_MASK is 0 read as zero, and writes to them have no effect.
- R8: Strobes on consecutive cycles each get exactly one acknowledge, in order, with the data for their own address.
- R9: After reset every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_stb | input | 1 | Request strobe for this slot |
| i_we | input | 1 | Write enable |
| i_addr | input | ADDR_W | Word address |
| i_data | input | 32 | Write data |
| i_sel | input | 4 | Byte lane selects |
| o_ack | output | 1 | Acknowledge |
| o_stall | output | 1 | Stall, held low |
| o_err | output | 1 | Error, held low |
| o_data | output | 32 | Read data |

## Verification
Both classes are driven from the same bus inputs, so every stimulus cycle checks same-cycle and next-cycle acknowledge at once. An address sweep writes a distinct word to every index, with the ignored high address bits varying, and then reads them back. This separates index aliasing, unpopulated members and wrong member decode. A sweep of all sixteen byte-select values over a known background shows whether a lane is taken from the wrong enable bit. Back-to-back strobe runs with idle gaps between them, including writes followed at once by reads of the same address, expose lost or duplicated acknowledges and data captured after the write instead of before it.

// File: rtl/wbrg_pkg.sv
package wbrg_pkg;
   typedef enum logic {
      GRP_IMMEDIATE = 1'b0,
      GRP_ONE_CYCLE = 1'b1
   } grp_class_e;

   localparam int WORD_W = 32;
   localparam int LANES  = WORD_W / 8;

   function automatic logic [WORD_W-1:0] lane_merge(
      input logic [WORD_W-1:0] cur,
      input logic [WORD_W-1:0] upd,
      input logic [LANES-1:0]  sel
   );
      logic [WORD_W-1:0] res;
      res = cur;
      for (int b = 0; b < LANES; b++) begin
         if (sel[b]) res[b*8 +: 8] = upd[b*8 +: 8];
      end
      return res;
   endfunction
endpackage

// File: rtl/wbrg_decode.sv
module wbrg_decode #(
   parameter int NUM_MEMBERS = 4,
   localparam int MIDX_W = $clog2(NUM_MEMBERS)
) (
   input  logic                   stb,
   input  logic [MIDX_W-1:0]      midx,
   output logic [NUM_MEMBERS-1:0] stb_vec
);
   for (genvar m = 0; m < NUM_MEMBERS; m++) begin : g_sel
      assign stb_vec[m] = stb && (midx == MIDX_W'(m));
   end
endmodule

// File: rtl/wbrg_member.sv
module wbrg_member #(
   parameter int WORDS = 4,
   localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              stb,
   input  logic                              we,
   input  logic [SEL_W-1:0]                  widx,
   input  logic [wbrg_pkg::WORD_W-1:0]       wdata,
   input  logic [wbrg_pkg::LANES-1:0]        wsel,
   output logic [WORDS-1:0][wbrg_pkg::WORD_W-1:0] regs_o
);
   logic [WORDS-1:0][wbrg_pkg::WORD_W-1:0] store;

   if (WORDS == 1) begin : g_single
      logic unused_idx;
      assign unused_idx = ^widx;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) store <= '0;
         else if (stb && we) store[0] <= wbrg_pkg::lane_merge(store[0], wdata, wsel);
      end
   end else begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) store <= '0;
         else if (stb && we) store[widx] <= wbrg_pkg::lane_merge(store[widx], wdata, wsel);
      end
   end

   assign regs_o = store;
endmodule

// File: rtl/wbrg_return.sv
module wbrg_return #(
   parameter wbrg_pkg::grp_class_e GRP_CLASS = wbrg_pkg::GRP_ONE_CYCLE,
   parameter int ENTRIES = 16,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     stb,
   input  logic [IDX_W-1:0]                         idx,
   input  logic [ENTRIES-1:0][wbrg_pkg::WORD_W-1:0] words,
   output logic                                     ack,
   output logic [wbrg_pkg::WORD_W-1:0]              data
);
   if (GRP_CLASS == wbrg_pkg::GRP_IMMEDIATE) begin : g_imm
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign ack  = stb;
      assign data = words[idx];
   end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ack  <= 1'b0;
            data <= '0;
         end else begin
            ack <= stb;
            if (stb) data <= words[idx];
         end
      end
   end
endmodule

// File: rtl/wb_reg_group.sv
module wb_reg_group #(
   parameter wbrg_pkg::grp_class_e GRP_CLASS = wbrg_pkg::GRP_ONE_CYCLE,
   parameter int          NUM_MEMBERS     = 4,
   parameter int          REGS_PER_MEMBER = 4,
   parameter logic [15:0] POP_MASK        = 16'h000B,
   parameter int          ADDR_W          = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         i_stb,
   input  logic                         i_we,
   input  logic [ADDR_W-1:0]            i_addr,
   input  logic [wbrg_pkg::WORD_W-1:0]  i_data,
   input  logic [wbrg_pkg::LANES-1:0]   i_sel,
   output logic                         o_ack,
   output logic                         o_stall,
   output logic                         o_err,
   output logic [wbrg_pkg::WORD_W-1:0]  o_data
);
   localparam bit IS_IMM  = (GRP_CLASS == wbrg_pkg::GRP_IMMEDIATE);
   localparam int RPM     = IS_IMM ? 1 : REGS_PER_MEMBER;
   localparam int RIDX_W  = IS_IMM ? 0 : $clog2(REGS_PER_MEMBER);
   localparam int RSEL_W  = (RIDX_W > 0) ? RIDX_W : 1;
   localparam int MIDX_W  = $clog2(NUM_MEMBERS);
   localparam int IDX_W   = MIDX_W + RIDX_W;
   localparam int ENTRIES = NUM_MEMBERS * RPM;

   if (!(NUM_MEMBERS inside {2, 4, 8, 16})) begin : g_chk_members
      $error("NUM_MEMBERS must be 2, 4, 8 or 16");
   end
   if (!IS_IMM && !(REGS_PER_MEMBER inside {2, 4, 8, 16})) begin : g_chk_regs
      $error("REGS_PER_MEMBER must be 2, 4, 8 or 16");
   end
   if (ADDR_W < IDX_W) begin : g_chk_addr
      $error("ADDR_W too narrow for the register index");
   end

   logic [IDX_W-1:0]       idx;
   logic [MIDX_W-1:0]      midx;
   logic [RSEL_W-1:0]      ridx;
   logic [NUM_MEMBERS-1:0] mstb;
   logic [ENTRIES-1:0][wbrg_pkg::WORD_W-1:0] all_words;

   assign idx  = i_addr[IDX_W-1:0];
   assign midx = idx[IDX_W-1:RIDX_W];

   if (RIDX_W > 0) begin : g_ridx
      assign ridx = idx[RSEL_W-1:0];
   end else begin : g_noridx
      assign ridx = '0;
   end

   if (ADDR_W > IDX_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^i_addr[ADDR_W-1:IDX_W];
   end

   wbrg_decode #(.NUM_MEMBERS(NUM_MEMBERS)) u_decode (
      .stb     (i_stb),
      .midx    (midx),
      .stb_vec (mstb)
   );

   for (genvar m = 0; m < NUM_MEMBERS; m++) begin : g_mem
      if (POP_MASK[m]) begin : g_pop
         wbrg_member #(.WORDS(RPM)) u_member (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (mstb[m]),
            .we     (i_we),
            .widx   (ridx),
            .wdata  (i_data),
            .wsel   (i_sel),
            .regs_o (all_words[m*RPM +: RPM])
         );
      end else begin : g_empty
         assign all_words[m*RPM +: RPM] = '0;
      end
   end

   wbrg_return #(.GRP_CLASS(GRP_CLASS), .ENTRIES(ENTRIES)) u_return (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (i_stb),
      .idx   (idx),
      .words (all_words),
      .ack   (o_ack),
      .data  (o_data)
   );

   assign o_stall = 1'b0;
   assign o_err   = 1'b0;
endmodule

// File: rtl/wbrg_checker.sv
module wbrg_checker #(
   parameter wbrg_pkg::grp_class_e GRP_CLASS = wbrg_pkg::GRP_ONE_CYCLE,
   parameter int          NUM_MEMBERS     = 4,
   parameter int          REGS_PER_MEMBER = 4,
   parameter logic [15:0] POP_MASK        = 16'h000B,
   parameter int          ADDR_W          = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              i_stb,
   input logic              i_we,
   input logic [ADDR_W-1:0] i_addr,
   input logic              o_ack,
   input logic              o_stall,
   input logic              o_err,
   input logic [31:0]       o_data
);
   localparam bit IS_IMM = (GRP_CLASS == wbrg_pkg::GRP_IMMEDIATE);
   localparam int RIDX_W = IS_IMM ? 0 : $clog2(REGS_PER_MEMBER);
   localparam int MIDX_W = $clog2(NUM_MEMBERS);
   localparam int IDX_W  = MIDX_W + RIDX_W;

   logic [MIDX_W-1:0] midx;
   logic              unpop;
   assign midx  = i_addr[IDX_W-1:RIDX_W];
   assign unpop = !POP_MASK[midx];

   a_r2_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      !o_stall && !o_err);

   if (IS_IMM) begin : g_imm
      a_r1_same_cycle_ack: assert property (@(posedge clk) disable iff (!rst_n)
         i_stb |-> o_ack);
      a_r1_idle_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
         !i_stb |-> !o_ack);
      a_r7_unpop_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (i_stb && unpop) |-> (o_data == 32'h0));
   end else begin : g_reg
      a_r3_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
         i_stb |=> o_ack);
      a_r8_no_extra_ack: assert property (@(posedge clk) disable iff (!rst_n)
         !i_stb |=> !o_ack);
      a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !i_stb |=> $stable(o_data));
      a_r7_unpop_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (i_stb && unpop) |=> (o_data == 32'h0));
   end
endmodule

bind wb_reg_group wbrg_checker #(
   .GRP_CLASS       (GRP_CLASS),
   .NUM_MEMBERS     (NUM_MEMBERS),
   .REGS_PER_MEMBER (REGS_PER_MEMBER),
   .POP_MASK        (POP_MASK),
   .ADDR_W          (ADDR_W)
) u_chk (.*);

// File: tb/wb_reg_group_bench.sv
`timescale 1ns/100ps
module wb_reg_group_bench;
   localparam logic [15:0] POP_OC = 16'h000B;
   localparam logic [15:0] POP_IM = 16'h00BD;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic i_stb = 1'b0, i_we = 1'b0;
   logic [7:0] i_addr = '0;
   logic [31:0] i_data = '0;
   logic [3:0] i_sel = '0;
   logic ack_oc, stall_oc, err_oc, ack_im, stall_im, err_im;
   logic [31:0] data_oc, data_im;

   int checks = 0, errors = 0;
   int stb_count = 0, ack_count = 0;
   logic [31:0] model_oc [16];
   logic [31:0] model_im [8];

   always #2.5 clk = ~clk;

   wb_reg_group #(.GRP_CLASS(wbrg_pkg::GRP_ONE_CYCLE), .NUM_MEMBERS(4),
                  .REGS_PER_MEMBER(4), .POP_MASK(POP_OC), .ADDR_W(8)) u_wb_reg_group (
      .clk(clk), .rst_n(rst_n), .i_stb(i_stb), .i_we(i_we), .i_addr(i_addr),
      .i_data(i_data), .i_sel(i_sel), .o_ack(ack_oc), .o_stall(stall_oc),
      .o_err(err_oc), .o_data(data_oc));

   wb_reg_group #(.GRP_CLASS(wbrg_pkg::GRP_IMMEDIATE), .NUM_MEMBERS(8),
                  .REGS_PER_MEMBER(4), .POP_MASK(POP_IM), .ADDR_W(8)) u_wb_reg_group_imm (
      .clk(clk), .rst_n(rst_n), .i_stb(i_stb), .i_we(i_we), .i_addr(i_addr),
      .i_data(i_data), .i_sel(i_sel), .o_ack(ack_im), .o_stall(stall_im),
      .o_err(err_im), .o_data(data_im));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] expect_merge(input logic [31:0] cur, input logic [31:0] upd, input logic [3:0] sel);
      logic [31:0] mask;
      mask = {{8{sel[3]}}, {8{sel[2]}}, {8{sel[1]}}, {8{sel[0]}}};
      return (upd & mask) | (cur & ~mask);
   endfunction

   task automatic bus(input bit stb, input bit we, input logic [7:0] a, input logic [31:0] d, input logic [3:0] sel);
      logic [31:0] exp_oc;
      @(negedge clk);
      i_stb = stb; i_we = we; i_addr = a; i_data = d; i_sel = sel;
      #1;
      chk(ack_im === stb, "R1 ack", {31'b0, ack_im}, {31'b0, stb});
      if (stb) chk(data_im === model_im[a[2:0]],
                   POP_IM[a[2:0]] ? "R1 data" : "R7 unpop imm", data_im, model_im[a[2:0]]);
      chk(!stall_oc && !err_oc && !stall_im && !err_im, "R2 stall/err",
          {28'b0, stall_oc, err_oc, stall_im, err_im}, 32'h0);
      exp_oc = model_oc[a[3:0]];
      @(posedge clk);
      #1;
      chk(ack_oc === stb, "R3/R8 ack", {31'b0, ack_oc}, {31'b0, stb});
      if (stb) begin
         stb_count++;
         chk(data_oc === exp_oc, POP_OC[a[3:2]] ? "R4/R6 data" : "R7 unpop oc", data_oc, exp_oc);
      end
      if (ack_oc) ack_count++;
      if (stb && we) begin
         if (POP_OC[a[3:2]]) model_oc[a[3:0]] = expect_merge(model_oc[a[3:0]], d, sel);
         if (POP_IM[a[2:0]]) model_im[a[2:0]] = expect_merge(model_im[a[2:0]], d, sel);
      end
   endtask

   initial begin : watchdog
      #800000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) model_oc[i] = '0;
      for (int i = 0; i < 8; i++) model_im[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      chk(ack_oc === 1'b0 && ack_im === 1'b0, "R9 reset ack", {30'b0, ack_oc, ack_im}, 32'h0);
      chk(data_oc === 32'h0, "R9 reset data", data_oc, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: every register reads zero after reset (back-to-back reads, R8)
      for (int i = 0; i < 16; i++) bus(1, 0, 8'(i), 32'h0, 4'h0);
      bus(0, 0, 8'h0, 32'h0, 4'h0);

      // R6/R7: unique word per index, high address bits varying
      for (int i = 0; i < 16; i++)
         bus(1, 1, 8'(i | ((i * 5) << 4)), 32'h1000_0001 * (i + 1) ^ 32'h5A00_00A5, 4'hF);
      bus(0, 0, 8'h0, 32'h0, 4'h0);
      for (int i = 15; i >= 0; i--) bus(1, 0, 8'(i | ((15 - i) << 4)), 32'h0, 4'h0);

      // R5: every byte-select value over a known background
      for (int s = 0; s < 16; s++) begin
         bus(1, 1, 8'h06, 32'h0123_4567, 4'hF);
         bus(1, 1, 8'h06, 32'hA5C3_9E71, 4'(s));
         bus(1, 0, 8'h06, 32'h0, 4'h0);
         bus(0, 0, 8'h0, 32'h0, 4'h0);
         bus(1, 0, 8'h06, 32'h0, 4'h0);
      end

      // R4/R8: write then immediate read, with gaps and bursts
      for (int i = 0; i < 16; i++) begin
         bus(1, 1, 8'(i), ~(32'h0F0F_0000 + 32'(i)), 4'(15 - i));
         bus(1, 0, 8'(i), 32'h0, 4'h0);
         if (i % 3 == 0) bus(0, 1, 8'(i), 32'hDEAD_BEEF, 4'hF);
      end
      for (int i = 0; i < 16; i++) bus(1, 0, 8'(i ^ 5), 32'h0, 4'h0);
      bus(0, 0, 8'h0, 32'h0, 4'h0);

      chk(stb_count == ack_count, "R8 ack count", 32'(ack_count), 32'(stb_count));
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule